// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Strobed Format Register

This block is the sending half of an asynchronous serial port. It runs on the system clock and advances only on a one-cycle enable pulse, `tick`, that arrives sixteen times per bit period. Software writes a byte into a holding buffer with an active-low write strobe. When the shifter is free, the byte moves into the shifter on the next tick. The shifter then sends a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and a stop period on a line that rests high. Because the buffer empties as soon as its byte is handed over, the next byte can be written while the current one is still on the line. Characters then follow one another with no idle gap.

The character format sits in a small format register that is written while `cfg_load` is high. The shifter takes a private copy of that format at each hand-over, so the format of a character cannot change once it has started. The shifter is a five-state machine. `TX_IDLE` moves to `TX_START` on a tick when the buffer is full. `TX_START` moves to `TX_DATA` after 16 ticks. `TX_DATA` moves to `TX_PARITY` after the last data bit, or straight to `TX_STOP` when parity is switched off. `TX_PARITY` moves to `TX_STOP` after 16 ticks. `TX_STOP` moves back to `TX_START` if the buffer is full when the stop period ends, and to `TX_IDLE` otherwise.

Top module: `uart_tx_dbuf`

## Requirements
- R1: A clock edge with `rst` high sets `buf_empty` to 1, `shift_empty` to 1 and `ser_out` to 1 for the next cycle, even in the middle of a character. A byte waiting in the buffer is dropped.
- R2: A rising clock edge with `buf_load_n` low stores `buf_data` in the buffer, and `buf_empty` reads 0 from the next cycle.
- R3: While the shifter is idle and the buffer is full, the first tick edge starts a character. From the cycle after that edge, `buf_empty` is 1, `shift_empty` is 0 and `ser_out` is 0. The start bit lasts 16 ticks. Nothing changes before that tick.
- R4: The data bits follow the start bit, least significant bit first, each lasting 16 ticks. `cfg_len` encodes the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R5: With `cfg_par_off` at 0, one 16-tick parity bit follows the data. With `cfg_par_even` at 1, the data bits and the parity bit together hold an even number of ones. With `cfg_par_even` at 0, they hold an odd number. With `cfg_par_off` at 1, no parity bit is sent.
- R6: The stop period holds `ser_out` high. It lasts 16 ticks when `cfg_stop2` is 0. When `cfg_stop2` is 1, it lasts 32 ticks, or 24 ticks for 5-bit characters.
- R7: If the buffer is empty when the last stop tick arrives, `shift_empty` rises after that tick edge. If the buffer is full, the next start bit begins at that same edge and `shift_empty` stays 0.
- R8: The format register takes `cfg_len`, `cfg_par_even`, `cfg_par_off` and `cfg_stop2` on a clock edge where `cfg_load` is 1, and ignores them at any other edge. After reset it holds 8 data bits, parity off and one stop bit.
- R9: `ser_out` changes only on tick edges or under reset. `buf_empty` and `shift_empty` rise only on tick edges or under reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous master reset, active high |
| tick | input | 1 | One-cycle enable pulse at 16 times the bit rate |
| cfg_load | input | 1 | Format register write, active high |
| cfg_len | input | 2 | Data length code: 00=5 to 11=8 bits |
| cfg_par_even | input | 1 | 1 for even parity, 0 for odd parity |
| cfg_par_off | input | 1 | 1 to send no parity bit |
| cfg_stop2 | input | 1 | 1 for the long stop period (2 bits, or 1.5 bits for 5-bit characters) |
| buf_load_n | input | 1 | Buffer write strobe, active low |
| buf_data | input | DATA_W | Byte to write into the buffer |
| buf_empty | output | 1 | Buffer holds no byte |
| shift_empty | output | 1 | Shifter is idle, line resting high |
| ser_out | output | 1 | Serial output |

## Verification
Buffer writes are checked one cycle after the write edge. The hand-over is checked at the first falling clock edge after the next tick edge, when `buf_empty`, `shift_empty` and the start bit must all have changed together. Every serial bit is sampled at its midpoint, 8 ticks into the bit, by counting tick edges rather than clock cycles from the edge that started the character. This keeps the checks independent of how ticks are spaced. The length of the stop period is checked one tick before its end and again at its end. At the end, the check accepts either a rising `shift_empty` or an immediate new start bit, and for a new start bit it also requires that a byte had been queued.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_t;

    typedef struct packed {
        logic [1:0] len;
        logic       par_even;
        logic       par_off;
        logic       stop2;
    } tx_cfg_t;

    // 8 data bits, no parity, one stop bit
    localparam tx_cfg_t CFG_RESET = '{len: 2'b11, par_even: 1'b0, par_off: 1'b1, stop2: 1'b0};

endpackage

// File: rtl/uart_tx_cfg_reg.sv
module uart_tx_cfg_reg
    import uart_tx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  tx_cfg_t d,
    output tx_cfg_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= CFG_RESET;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/uart_tx_holdbuf.sv
module uart_tx_holdbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic [W-1:0] din,
    input  logic         take,
    output logic [W-1:0] dout,
    output logic         empty
);

    // a write on the hand-over edge wins: the new byte stays held
    always_ff @(posedge clk) begin
        if (rst) begin
            empty <= 1'b1;
        end else if (!load_n) begin
            empty <= 1'b0;
        end else if (take) begin
            empty <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (!load_n) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int W   = 8,
    parameter int OVS = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  tx_cfg_t      cfg,
    input  logic         buf_full,
    input  logic [W-1:0] buf_data,
    output logic         take,
    output logic         ser_out,
    output logic         shift_empty
);

    localparam int STOP_LONG  = 2 * OVS;
    localparam int STOP_SHORT = OVS;
    localparam int STOP_MID   = OVS + OVS / 2;
    localparam int CNT_W      = $clog2(STOP_LONG);
    localparam int IDX_W      = $clog2(W);
    localparam int LEN_BASE   = W - 3;

    tx_state_t         state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [W-1:0]      shreg;
    logic              par_bit;
    logic [1:0]        f_len;
    logic              f_off;
    logic              f_stop2;

    logic [CNT_W-1:0]  stop_last;
    logic [IDX_W-1:0]  last_idx;
    logic              bit_end;
    logic              stop_end;
    logic [W-1:0]      len_mask;
    logic              data_xor;
    logic              par_calc;

    always_comb begin
        if (!f_stop2) begin
            stop_last = CNT_W'(STOP_SHORT - 1);
        end else if (f_len == 2'b00) begin
            stop_last = CNT_W'(STOP_MID - 1);
        end else begin
            stop_last = CNT_W'(STOP_LONG - 1);
        end
    end

    assign last_idx = IDX_W'(LEN_BASE - 1) + IDX_W'(f_len);
    assign bit_end  = tick && (cnt == CNT_W'(OVS - 1));
    assign stop_end = tick && (cnt == stop_last);

    assign len_mask = {W{1'b1}} >> (2'd3 - cfg.len);
    assign data_xor = ^(buf_data & len_mask);
    assign par_calc = cfg.par_even ? data_xor : ~data_xor;

    assign take = buf_full && (((state == TX_IDLE) && tick) ||
                               ((state == TX_STOP) && stop_end));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:   if (take) state_nx = TX_START;
            TX_START:  if (bit_end) state_nx = TX_DATA;
            TX_DATA:   if (bit_end && (idx == last_idx))
                           state_nx = f_off ? TX_STOP : TX_PARITY;
            TX_PARITY: if (bit_end) state_nx = TX_STOP;
            TX_STOP:   if (stop_end) state_nx = take ? TX_START : TX_IDLE;
            default:   state_nx = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // datapath: tick counter, bit index, shift register, frame format copy
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            f_len   <= CFG_RESET.len;
            f_off   <= CFG_RESET.par_off;
            f_stop2 <= CFG_RESET.stop2;
        end else if (take) begin
            cnt     <= '0;
            idx     <= '0;
            shreg   <= buf_data;
            par_bit <= par_calc;
            f_len   <= cfg.len;
            f_off   <= cfg.par_off;
            f_stop2 <= cfg.stop2;
        end else if (tick && (state != TX_IDLE)) begin
            if ((state == TX_STOP) ? stop_end : bit_end) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
            if ((state == TX_DATA) && bit_end) begin
                shreg <= shreg >> 1;
                idx   <= idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            TX_IDLE:   begin ser_out = 1'b1;     shift_empty = 1'b1; end
            TX_START:  begin ser_out = 1'b0;     shift_empty = 1'b0; end
            TX_DATA:   begin ser_out = shreg[0]; shift_empty = 1'b0; end
            TX_PARITY: begin ser_out = par_bit;  shift_empty = 1'b0; end
            TX_STOP:   begin ser_out = 1'b1;     shift_empty = 1'b0; end
            default:   begin ser_out = 1'b1;     shift_empty = 1'b1; end
        endcase
    end

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cfg_load,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_even,
    input  logic              cfg_par_off,
    input  logic              cfg_stop2,
    input  logic              buf_load_n,
    input  logic [DATA_W-1:0] buf_data,
    output logic              buf_empty,
    output logic              shift_empty,
    output logic              ser_out
);

    tx_cfg_t           cfg_in;
    tx_cfg_t           cfg_q;
    logic [DATA_W-1:0] hold_q;
    logic              take;

    assign cfg_in = '{len: cfg_len, par_even: cfg_par_even,
                      par_off: cfg_par_off, stop2: cfg_stop2};

    uart_tx_cfg_reg i_cfg (
        .clk  (clk),
        .rst  (rst),
        .load (cfg_load),
        .d    (cfg_in),
        .q    (cfg_q)
    );

    uart_tx_holdbuf #(.W(DATA_W)) i_hold (
        .clk    (clk),
        .rst    (rst),
        .load_n (buf_load_n),
        .din    (buf_data),
        .take   (take),
        .dout   (hold_q),
        .empty  (buf_empty)
    );

    uart_tx_shifter #(.W(DATA_W), .OVS(OVS)) i_shift (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .cfg         (cfg_q),
        .buf_full    (!buf_empty),
        .buf_data    (hold_q),
        .take        (take),
        .ser_out     (ser_out),
        .shift_empty (shift_empty)
    );

endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic buf_load_n,
    input logic buf_empty,
    input logic shift_empty,
    input logic ser_out
);

    // R1
    a_r1_reset_flags: assert property (@(posedge clk)
        rst |=> (buf_empty && shift_empty && ser_out));

    // R2
    a_r2_load_fills: assert property (@(posedge clk) disable iff (rst)
        !buf_load_n |=> !buf_empty);

    // R3
    a_r3_start_with_handover: assert property (@(posedge clk) disable iff (rst)
        ($fell(shift_empty) && $past(buf_load_n)) |-> (!ser_out && buf_empty));

    // R9
    a_r9_line_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(ser_out));

    // R9
    a_r9_buf_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_empty) |-> ($past(tick) || $past(rst)));

    // R7
    a_r7_idle_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(shift_empty) |-> ($past(tick) || $past(rst)));

endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .buf_load_n  (buf_load_n),
    .buf_empty   (buf_empty),
    .shift_empty (shift_empty),
    .ser_out     (ser_out)
);

// File: tb/test_uart_tx_dbuf.sv
module test_uart_tx_dbuf;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       cfg_load = 1'b0;
    logic [1:0] cfg_len = 2'b00;
    logic       cfg_par_even = 1'b0;
    logic       cfg_par_off = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       buf_load_n = 1'b1;
    logic [7:0] buf_data = 8'h00;
    logic       buf_empty, shift_empty, ser_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit mon_off = 1'b0;

    // format the bench believes is loaded (R8 reset value)
    logic [1:0] m_len = 2'b11;
    logic       m_even = 1'b0;
    logic       m_off = 1'b1;
    logic       m_stop2 = 1'b0;

    logic [7:0] q [0:255];
    int wr = 0;
    int rd = 0;

    always #2.5 clk = ~clk;

    uart_tx_dbuf i_uart_tx_dbuf (
        .clk(clk), .rst(rst), .tick(tick), .cfg_load(cfg_load),
        .cfg_len(cfg_len), .cfg_par_even(cfg_par_even), .cfg_par_off(cfg_par_off),
        .cfg_stop2(cfg_stop2), .buf_load_n(buf_load_n), .buf_data(buf_data),
        .buf_empty(buf_empty), .shift_empty(shift_empty), .ser_out(ser_out)
    );

    // tick every fourth clock, driven on the falling edge
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div = (div + 1) % 4;
            tick = (div == 3);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // return at the falling edge after the n-th tick edge
    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!tick) @(posedge clk);
        end
        @(negedge clk);
    endtask

    function automatic logic exp_parity(input logic [7:0] d, input int n, input logic even);
        logic [7:0] m;
        m = d & 8'((1 << n) - 1);
        return even ? ^m : ~^m;
    endfunction

    function automatic int exp_stop(input int n, input logic s2);
        if (!s2) return 16;
        return (n == 5) ? 24 : 32;
    endfunction

    task automatic frame();
        int n;
        logic ev, off, s2;
        logic [7:0] d;
        n = 5 + int'(m_len);
        ev = m_even; off = m_off; s2 = m_stop2;
        d = q[rd];
        rd++;
        wait_ticks(8);
        chk(ser_out == 1'b0, "R3 start bit mid", ser_out, 0);
        for (int i = 0; i < n; i++) begin
            wait_ticks(16);
            chk(ser_out == d[i], "R4 data bit", ser_out, d[i]);
        end
        if (!off) begin
            wait_ticks(16);
            chk(ser_out == exp_parity(d, n, ev), "R5 parity bit", ser_out, exp_parity(d, n, ev));
        end
        wait_ticks(8);
        chk(ser_out == 1'b1, "R6 stop begins high", ser_out, 1);
        wait_ticks(exp_stop(n, s2) - 1);
        chk(ser_out == 1'b1 && shift_empty == 1'b0, "R6 stop still running",
            {ser_out, shift_empty}, 2);
        wait_ticks(1);
        if (ser_out == 1'b0) begin
            chk(shift_empty == 1'b0 && rd < wr, "R7 back-to-back start", shift_empty, 0);
        end else begin
            chk(shift_empty == 1'b1, "R7 idle after stop", shift_empty, 1);
        end
    endtask

    // serial monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!mon_off && rst == 1'b0 && ser_out === 1'b0) frame();
        end
    end

    task automatic wait_idle();
        while (!(buf_empty && shift_empty)) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        while (!buf_empty) @(negedge clk);
        q[wr] = b;
        wr++;
        buf_data = b;
        buf_load_n = 1'b0;
        @(negedge clk);
        buf_load_n = 1'b1;
        chk(buf_empty == 1'b0, "R2 buffer full after write", buf_empty, 0);
    endtask

    task automatic setcfg(input logic [1:0] l, input logic ev, input logic off, input logic s2);
        wait_idle();
        cfg_len = l; cfg_par_even = ev; cfg_par_off = off; cfg_stop2 = s2;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        m_len = l; m_even = ev; m_off = off; m_stop2 = s2;
    endtask

    // change the raw format inputs without a load (R8: ignored)
    task automatic scramble();
        cfg_len = ~m_len; cfg_par_even = ~m_even; cfg_par_off = ~m_off; cfg_stop2 = ~m_stop2;
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(buf_empty == 1'b1 && shift_empty == 1'b1 && ser_out == 1'b1,
            "R1 reset state", {buf_empty, shift_empty, ser_out}, 7);

        // R8 reset format, R3 hand-over timing, R7 back-to-back
        scramble();
        send(8'hA5);
        chk(shift_empty == 1'b1, "R3 no start before tick", shift_empty, 1);
        wait_ticks(1);
        chk(buf_empty == 1'b1 && shift_empty == 1'b0 && ser_out == 1'b0,
            "R3 hand-over on tick", {buf_empty, shift_empty, ser_out}, 4);
        send(8'h3C);
        wait_idle();

        // 5 bits, even parity, 1.5 stop
        setcfg(2'b00, 1'b1, 1'b0, 1'b1);
        scramble();
        send(8'h1B);
        send(8'h0E);
        wait_idle();

        // 6 bits, odd parity, 2 stop
        setcfg(2'b01, 1'b0, 1'b0, 1'b1);
        send(8'h2D);
        wait_idle();

        // 7 bits, no parity, 1 stop
        setcfg(2'b10, 1'b0, 1'b1, 1'b0);
        send(8'h7F);
        send(8'h00);
        wait_idle();

        // constrained random bursts
        for (int b = 0; b < 25; b++) begin
            setcfg(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 1) == 1) scramble();
            for (int k = 0; k < int'($urandom_range(1, 3)); k++) begin
                repeat ($urandom_range(0, 20)) @(negedge clk);
                send(8'($urandom_range(0, 255)));
            end
            wait_idle();
        end

        // R1 reset in mid character with a byte waiting
        repeat (80) @(negedge clk);
        mon_off = 1'b1;
        send(8'h96);
        wait_ticks(20);
        send(8'h69);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(buf_empty == 1'b1 && shift_empty == 1'b1 && ser_out == 1'b1,
            "R1 reset mid character", {buf_empty, shift_empty, ser_out}, 7);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule